// File: doc/BRIEF.md
# Glitch Pulse Sequencer

This block generates a timed train of glitch pulses for fault-injection experiments, optionally preceded by a power-cycle of the target device. A host-side front end, which is not part of the block, holds five timing values (delay before the first pulse, pulse width, pulse count, gap between pulses and target-reset length) and a two-bit reset-mode code. It presents them to the block as plain register inputs, together with single-cycle command strobes. All durations are counted in cycles of the block clock (20 ns at 50 MHz).

A sequence starts in one of three ways. A software trigger strobe starts it at once. An asynchronous external trigger pin starts it after a two-flop synchronizer, but only while the block is armed; the pin acts on its level, and arming is consumed by the start. A target-reset strobe can also lead to it, depending on the reset mode. The reset strobe drives the target reset output for the configured length, and the reset mode then chooses among three follow-ups: run the pulse sequence, return to idle armed, or return to idle. Besides the pulse and reset outputs, the block drives their complements, their OR, a one-cycle start marker for scope triggering, a busy flag and an armed flag.

Top module: `glitch_seq`

## Requirements
- R1: After reset the block is idle and not armed: pulse, target reset, combined, start and busy outputs are 0; both inverted outputs are 1.
- R2: Every timing value (delay, width, spacing, reset length) lasts max(value,1) cycles: 0 and 1 both give one cycle, and N > 1 gives N cycles.
- R3: A trigger strobe in idle enters the delay phase on the next edge. Pulses of the configured width follow, separated by spacing gaps that occur only between pulses. The pulse count is max(count,1). Busy drops on the edge right after the last pulse cycle.
- R4: The start output is high for exactly one cycle, the first delay cycle of each sequence, and at no other time.
- R5: An arm strobe in idle toggles the armed state, which is visible on the armed output from the next edge.
- R6: The external trigger pin passes through two synchronizer flops and acts on level. With the block armed and idle, a pin sampled high at edge k gives the first delay cycle after edge k+2. The armed flag is 0 from that cycle. While the block is not armed, the pin has no effect.
- R7: A reset strobe in idle drives the target reset output high for max(length,1) cycles. With reset mode 2'b00 (Pulse, the all-zero value), the delay phase then starts on the next cycle, with the start marker.
- R8: With reset mode 2'b01 (Arm), the end of the reset interval returns the block to idle with armed = 1. Reset modes 2'b10 and 2'b11 (None) return it to idle with armed unchanged and no pulses.
- R9: Trigger, arm and reset strobes that arrive while busy are ignored: the sequence in progress and the armed flag are unaffected.
- R10: The inverted pulse and reset outputs are the exact complements of pulse and reset. The combined output is their OR. Pulse is high only in the pulse phase, and reset only in the reset phase.
- R11: Strobes arriving together in idle are resolved by priority: reset strobe, then trigger strobe, then external trigger, then arm strobe. Only the winner acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_delay | input | 16 | Cycles from sequence start to first pulse |
| cfg_width | input | 8 | Pulse high time in cycles |
| cfg_count | input | 8 | Number of pulses |
| cfg_space | input | 16 | Low time between consecutive pulses |
| cfg_rst_len | input | 16 | Target reset high time in cycles |
| cfg_rmode | input | 2 | Follow-up after reset: 00 Pulse, 01 Arm, 1x None |
| go_stb | input | 1 | One-cycle software trigger |
| arm_stb | input | 1 | One-cycle arm toggle |
| prst_stb | input | 1 | One-cycle target power-cycle request |
| trig_pin | input | 1 | Asynchronous external trigger, level sensitive |
| pulse_o | output | 1 | Glitch pulse, active high |
| pulse_n_o | output | 1 | Complement of pulse_o |
| trst_o | output | 1 | Target reset, active high |
| trst_n_o | output | 1 | Complement of trst_o |
| glitch_or_rst_o | output | 1 | OR of pulse_o and trst_o |
| start_o | output | 1 | One-cycle marker at sequence start |
| busy_o | output | 1 | High whenever the sequencer is not idle |
| armed_o | output | 1 | External trigger is armed |

## Verification
The hardest situations to reach are those where strobes or the trigger level meet the state machine at an awkward moment. One is strobes landing in the middle of a sequence. Another is a trigger pin already held high at the instant arming completes, and another is several strobes arriving in the same idle cycle. The bench reaches them by driving the strobes from inside its cycle-by-cycle trace, at a chosen index of a running sequence. It also keeps the pin high across a finished sequence and re-arms, and it pulses strobe pairs on the same edge. Every trace compares all eight outputs in every cycle against a timeline computed from the effective durations, so the 0-versus-1 duration rule and the missing trailing gap show up as cycle shifts.

// File: rtl/glitch_pkg.sv
package glitch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RESET = 3'd1,
        ST_DELAY = 3'd2,
        ST_PULSE = 3'd3,
        ST_SPACE = 3'd4
    } gl_state_e;

    // reset follow-up codes; any other value behaves as "none"
    localparam logic [1:0] RM_PULSE = 2'b00;
    localparam logic [1:0] RM_ARM   = 2'b01;

endpackage

// File: rtl/glitch_sync.sv
module glitch_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/glitch_timer.sv
module glitch_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             done
);

    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

    // R2: an unloaded, unfinished count steps down by exactly one
    p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R2: a load of zero finishes after a single cycle
    p_zero_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> done);

endmodule

// File: rtl/glitch_fsm.sv
module glitch_fsm
    import glitch_pkg::*;
#(
    parameter int DLY_W = 16,
    parameter int WID_W = 8,
    parameter int CNT_W = 8,
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic [WID_W-1:0] cfg_width,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [DLY_W-1:0] cfg_space,
    input  logic [DLY_W-1:0] cfg_rst_len,
    input  logic [1:0]       cfg_rmode,
    input  logic             go_stb,
    input  logic             arm_stb,
    input  logic             prst_stb,
    input  logic             trig_sync,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output gl_state_e        state_o,
    output logic             start_o,
    output logic             armed_o
);

    typedef struct packed {
        gl_state_e        state;
        logic             armed;
        logic             start;
        logic [CNT_W-1:0] left;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    // duration register value -> timer preload (effective length minus one)
    function automatic logic [TMR_W-1:0] len_m1(input logic [TMR_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    logic [TMR_W-1:0] delay_ld, width_ld, space_ld, rst_ld;
    logic [CNT_W-1:0] count_eff;

    always_comb begin
        delay_ld  = len_m1(TMR_W'(cfg_delay));
        width_ld  = len_m1(TMR_W'(cfg_width));
        space_ld  = len_m1(TMR_W'(cfg_space));
        rst_ld    = len_m1(TMR_W'(cfg_rst_len));
        count_eff = (cfg_count == '0) ? CNT_W'(1) : cfg_count;
    end

    logic launch;

    always_comb begin
        r_d      = r_q;
        r_d.start = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        launch   = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (prst_stb) begin
                    r_d.state = ST_RESET;
                    tmr_load  = 1'b1;
                    tmr_val   = rst_ld;
                end else if (go_stb || (r_q.armed && trig_sync)) begin
                    launch = 1'b1;
                end else if (arm_stb) begin
                    r_d.armed = ~r_q.armed;
                end
            end
            ST_RESET: begin
                if (tmr_done) begin
                    if (cfg_rmode == RM_PULSE) begin
                        launch = 1'b1;
                    end else if (cfg_rmode == RM_ARM) begin
                        r_d.state = ST_IDLE;
                        r_d.armed = 1'b1;
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_DELAY: begin
                if (tmr_done) begin
                    r_d.state = ST_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = width_ld;
                end
            end
            ST_PULSE: begin
                if (tmr_done) begin
                    if (r_q.left <= CNT_W'(1)) begin
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.state = ST_SPACE;
                        r_d.left  = r_q.left - 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = space_ld;
                    end
                end
            end
            ST_SPACE: begin
                if (tmr_done) begin
                    r_d.state = ST_PULSE;
                    tmr_load  = 1'b1;
                    tmr_val   = width_ld;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase

        if (launch) begin
            r_d.state = ST_DELAY;
            r_d.armed = 1'b0;
            r_d.start = 1'b1;
            r_d.left  = count_eff;
            tmr_load  = 1'b1;
            tmr_val   = delay_ld;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, armed: 1'b0, start: 1'b0, left: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;
    assign start_o = r_q.start;
    assign armed_o = r_q.armed;

    // R4: the start marker never lasts two cycles
    p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.start |=> !r_q.start);

    // R6: arming is consumed by the start
    p_start_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.start |-> !r_q.armed);

    // R2: the delay phase holds until the timer finishes
    p_delay_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DELAY && !tmr_done) |=> (r_q.state == ST_DELAY));

    // R3: no gap after the final pulse
    p_last_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PULSE && tmr_done && r_q.left <= CNT_W'(1)) |=> (r_q.state == ST_IDLE));

    // R9: a running sequence never restarts itself
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE && r_q.state != ST_RESET) |=> !r_q.start);

endmodule

// File: rtl/glitch_seq.sv
module glitch_seq
    import glitch_pkg::*;
#(
    parameter int DLY_W   = 16,
    parameter int WID_W   = 8,
    parameter int CNT_W   = 8,
    parameter int SYNC_ST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic [WID_W-1:0] cfg_width,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [DLY_W-1:0] cfg_space,
    input  logic [DLY_W-1:0] cfg_rst_len,
    input  logic [1:0]       cfg_rmode,
    input  logic             go_stb,
    input  logic             arm_stb,
    input  logic             prst_stb,
    input  logic             trig_pin,
    output logic             pulse_o,
    output logic             pulse_n_o,
    output logic             trst_o,
    output logic             trst_n_o,
    output logic             glitch_or_rst_o,
    output logic             start_o,
    output logic             busy_o,
    output logic             armed_o
);

    localparam int TMR_W = (DLY_W > WID_W) ? DLY_W : WID_W;

    logic             trig_sync;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_done;
    gl_state_e        state;

    glitch_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (trig_pin),
        .sync_o  (trig_sync)
    );

    glitch_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    glitch_fsm #(
        .DLY_W (DLY_W),
        .WID_W (WID_W),
        .CNT_W (CNT_W),
        .TMR_W (TMR_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_delay   (cfg_delay),
        .cfg_width   (cfg_width),
        .cfg_count   (cfg_count),
        .cfg_space   (cfg_space),
        .cfg_rst_len (cfg_rst_len),
        .cfg_rmode   (cfg_rmode),
        .go_stb      (go_stb),
        .arm_stb     (arm_stb),
        .prst_stb    (prst_stb),
        .trig_sync   (trig_sync),
        .tmr_done    (tmr_done),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .state_o     (state),
        .start_o     (start_o),
        .armed_o     (armed_o)
    );

    always_comb begin
        pulse_o         = (state == ST_PULSE);
        trst_o          = (state == ST_RESET);
        pulse_n_o       = ~pulse_o;
        trst_n_o        = ~trst_o;
        glitch_or_rst_o = pulse_o | trst_o;
        busy_o          = (state != ST_IDLE);
    end

    // R10: pulse and target reset are never high together
    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pulse_o && trst_o));

    // R4: the start marker only appears while busy
    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> busy_o);

endmodule

// File: tb/glitch_seq_tb.sv
module glitch_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_delay = '0, cfg_space = '0, cfg_rst_len = '0;
    logic [7:0]  cfg_width = '0, cfg_count = '0;
    logic [1:0]  cfg_rmode = 2'b00;
    logic        go_stb = 1'b0, arm_stb = 1'b0, prst_stb = 1'b0, trig_pin = 1'b0;
    logic        pulse_o, pulse_n_o, trst_o, trst_n_o, glitch_or_rst_o, start_o, busy_o, armed_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    glitch_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_delay(cfg_delay), .cfg_width(cfg_width), .cfg_count(cfg_count),
        .cfg_space(cfg_space), .cfg_rst_len(cfg_rst_len), .cfg_rmode(cfg_rmode),
        .go_stb(go_stb), .arm_stb(arm_stb), .prst_stb(prst_stb), .trig_pin(trig_pin),
        .pulse_o(pulse_o), .pulse_n_o(pulse_n_o), .trst_o(trst_o), .trst_n_o(trst_n_o),
        .glitch_or_rst_o(glitch_or_rst_o), .start_o(start_o), .busy_o(busy_o), .armed_o(armed_o)
    );

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [7:0] outs();
        return {pulse_o, pulse_n_o, trst_o, trst_n_o, glitch_or_rst_o, start_o, busy_o, armed_o};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cfg(input int d, input int w, input int n, input int s, input int r, input logic [1:0] m);
        @(negedge clk);
        cfg_delay = 16'(d); cfg_width = 8'(w); cfg_count = 8'(n);
        cfg_space = 16'(s); cfg_rst_len = 16'(r); cfg_rmode = m;
    endtask

    // pulses the chosen strobes for one edge; returns at the negedge after it
    task automatic strobe(input bit g, input bit a, input bit p);
        @(negedge clk);
        go_stb = g; arm_stb = a; prst_stb = p;
        @(negedge clk);
        go_stb = 1'b0; arm_stb = 1'b0; prst_stb = 1'b0;
    endtask

    // cycle-by-cycle comparison of all outputs; index 0 is the current negedge
    task automatic trace(input int dv, input int wv, input int nv, input int sv,
                         input int roff, input bit seq, input bit arm0, input bit arm_end,
                         input int inj, input string req);
        int dd = eff(dv);
        int ww = eff(wv);
        int nn = eff(nv);
        int ss = eff(sv);
        int total = roff + (seq ? dd + nn * ww + (nn - 1) * ss : 0);
        int mism = 0;
        logic [7:0] first_act = '0;
        logic [7:0] first_exp = '0;
        for (int i = 0; i < total + 4; i++) begin
            logic ep, et, eb, es, ea;
            logic [7:0] ev;
            ep = 1'b0;
            if (seq && i >= roff + dd) begin
                int t = i - roff - dd;
                int k = t / (ww + ss);
                int r = t % (ww + ss);
                ep = (k < nn) && (r < ww);
            end
            et = (i < roff);
            eb = (i < total);
            es = seq && (i == roff);
            ea = (i < roff) ? arm0 : (seq ? 1'b0 : arm_end);
            ev = {ep, ~ep, et, ~et, ep | et, es, eb, ea};
            if (outs() !== ev) begin
                if (mism == 0) begin
                    first_act = outs();
                    first_exp = ev;
                end
                mism++;
            end
            if (i == inj) begin
                go_stb = 1'b1; arm_stb = 1'b1; prst_stb = 1'b1;
            end else if (i == inj + 1) begin
                go_stb = 1'b0; arm_stb = 1'b0; prst_stb = 1'b0;
            end
            @(negedge clk);
        end
        chk(mism == 0, req, "trace {p,pn,r,rn,or,start,busy,armed}", 32'(first_act), 32'(first_exp));
    endtask

    task automatic idle_quiet(input int cycles, input bit arm_exp, input string req);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            if (busy_o !== 1'b0 || armed_o !== arm_exp) bad++;
            @(negedge clk);
        end
        chk(bad == 0, req, "idle and armed hold", 32'(bad), 32'(0));
    endtask

    task automatic t_reset_state();
        // R1
        chk(outs() === 8'b0101_0000, "R1", "outputs after reset", 32'(outs()), 32'(8'b0101_0000));
    endtask

    task automatic t_basic();
        // R2/R3/R4: minimum values, 0 treated as 1
        cfg(0, 0, 0, 0, 0, 2'b00);
        strobe(1, 0, 0);
        trace(0, 0, 0, 0, 0, 1, 0, 0, -1, "R2");
        cfg(1, 1, 1, 1, 0, 2'b00);
        strobe(1, 0, 0);
        trace(1, 1, 1, 1, 0, 1, 0, 0, -1, "R2");
        cfg(5, 3, 3, 2, 0, 2'b00);
        strobe(1, 0, 0);
        trace(5, 3, 3, 2, 0, 1, 0, 0, -1, "R3");
        cfg(2, 4, 2, 0, 0, 2'b00);
        strobe(1, 0, 0);
        trace(2, 4, 2, 0, 0, 1, 0, 0, -1, "R4");
    endtask

    task automatic t_arm_toggle();
        strobe(0, 1, 0);
        chk(armed_o === 1'b1 && busy_o === 1'b0, "R5", "armed after first toggle", 32'(armed_o), 32'(1));
        strobe(0, 1, 0);
        chk(armed_o === 1'b0, "R5", "armed after second toggle", 32'(armed_o), 32'(0));
    endtask

    task automatic t_ext_trigger();
        cfg(0, 2, 2, 3, 0, 2'b00);
        // pin high while disarmed: no effect (R6)
        trig_pin = 1'b1;
        idle_quiet(8, 1'b0, "R6");
        trig_pin = 1'b0;
        idle_quiet(3, 1'b0, "R6");
        strobe(0, 1, 0);
        trig_pin = 1'b1;
        repeat (3) @(negedge clk);
        trace(0, 2, 2, 3, 0, 1, 1, 0, -1, "R6");
        // held high after use: disarmed, no retrigger
        idle_quiet(6, 1'b0, "R6");
        // re-arm with the level already high: fires next edge
        strobe(0, 1, 0);
        @(negedge clk);
        trace(0, 2, 2, 3, 0, 1, 1, 0, -1, "R6");
        trig_pin = 1'b0;
        idle_quiet(3, 1'b0, "R6");
    endtask

    task automatic t_reset_modes();
        cfg(2, 2, 1, 0, 4, 2'b00);
        strobe(0, 0, 1);
        trace(2, 2, 1, 0, 4, 1, 0, 0, -1, "R7");
        cfg(0, 0, 0, 0, 3, 2'b01);
        strobe(0, 0, 1);
        trace(0, 0, 0, 0, 3, 0, 0, 1, -1, "R8");
        strobe(0, 1, 0);
        chk(armed_o === 1'b0, "R8", "disarm after arm mode", 32'(armed_o), 32'(0));
        cfg(0, 0, 0, 0, 0, 2'b10);
        strobe(0, 0, 1);
        trace(0, 0, 0, 0, 1, 0, 0, 0, -1, "R8");
        cfg(0, 0, 0, 0, 2, 2'b11);
        strobe(0, 0, 1);
        trace(0, 0, 0, 0, 2, 0, 0, 0, -1, "R8");
    endtask

    task automatic t_busy_ignore();
        cfg(3, 5, 2, 4, 0, 2'b00);
        strobe(1, 0, 0);
        trace(3, 5, 2, 4, 0, 1, 0, 0, 4, "R9");
        strobe(1, 0, 0);
        trace(3, 5, 2, 4, 0, 1, 0, 0, 12, "R9");
        // strobes during a reset interval are ignored too
        cfg(1, 1, 1, 0, 6, 2'b10);
        strobe(0, 0, 1);
        trace(1, 1, 1, 0, 6, 0, 0, 0, 2, "R9");
    endtask

    task automatic t_priority();
        cfg(0, 0, 0, 0, 2, 2'b10);
        strobe(1, 0, 1);
        trace(0, 0, 0, 0, 2, 0, 0, 0, -1, "R11");
        cfg(1, 2, 1, 0, 0, 2'b10);
        strobe(1, 1, 0);
        trace(1, 2, 1, 0, 0, 1, 0, 0, -1, "R11");
        chk(armed_o === 1'b0, "R11", "arm lost to trigger", 32'(armed_o), 32'(0));
    endtask

    task automatic t_complements();
        int bad = 0;
        cfg(1, 3, 2, 2, 3, 2'b00);
        strobe(0, 0, 1);
        for (int i = 0; i < 16; i++) begin
            if (pulse_n_o !== ~pulse_o || trst_n_o !== ~trst_o ||
                glitch_or_rst_o !== (pulse_o | trst_o)) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R10", "complement and OR outputs", 32'(bad), 32'(0));
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_basic();
        t_arm_toggle();
        t_ext_trigger();
        t_reset_modes();
        t_busy_ignore();
        t_priority();
        t_complements();
        done_flag = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end

endmodule